// File: doc/BRIEF.md
# Dual-Issue Prioritized Warp Scheduler

This block holds the two warp schedulers of one compute core. Each scheduler looks after its own pool of warps. Every cycle it picks one warp whose next instruction has all of its operands and whose target execution group is free. The pick goes by priority first, then round-robin among warps of equal priority. The block raises an issue grant that carries the warp id and the target unit group. Operand tracking happens outside the block, which only sees a ready flag per warp. The block does not model the datapath.

There are four execution groups. Each scheduler owns one 16-lane integer/FP32 group. The two schedulers share one group of 4 special-function units and one 16-unit load/store group. A double-precision instruction takes both integer/FP32 groups at once and stops the other scheduler from issuing while it runs. Each group stays busy for as many cycles as a full 32-thread warp needs, and the block shows that on a per-group busy vector. When both schedulers want the same resource in the same cycle, a fixed alternation picks the winner. At most one instruction issues per scheduler every two cycles, so the core's peak is two instructions every two cycles.

Top module: `dual_warp_issue`

## Requirements
- R1: A warp can be granted only while its ready input bit is 1. A warp that is not ready is never granted, whatever its priority.
- R2: Each warp has a 2-bit priority, and 3 is the most urgent. A warp's priority is bits [2w+1:2w] of sN_prio. A scheduler grants the most urgent of its eligible warps. A warp is eligible when it is ready, the scheduler's issue slot is free and the groups its class needs are free.
- R3: Warps of equal priority are searched in round-robin order. The search starts at the warp after the one last granted by the same scheduler and wraps from the last warp to warp 0.
- R4: Class code 0 (integer/FP32) from scheduler s goes to group s. That group is busy for 2 cycles, so grp_busy[s] is 1 in the cycle after the grant.
- R5: Class code 1 (special function) goes to the shared group, and grp_busy[2] is 1 for the 7 cycles after the grant. No class-1 grant from either scheduler is made while grp_busy[2] is 1.
- R6: Class code 2 (load/store) goes to the shared group, and grp_busy[3] is 1 in the cycle after the grant. No class-2 grant is made while grp_busy[3] is 1.
- R7: Class code 3 (double precision) needs both grp_busy[0] and grp_busy[1] clear. It is granted alone in its cycle and sets both of those bits for the next cycle. The other scheduler grants nothing in that next cycle either.
- R8: Each scheduler grants at most once every 2 cycles. Two schedulers with no conflict both grant in the same cycle.
- R9: A conflict is two candidates that both need the special-function group, both need the load/store group, or include a double-precision candidate. On a conflict, scheduler 0 wins on even cycles and scheduler 1 on odd cycles, with the first cycle after reset counted as cycle 0. The loser grants nothing and keeps its round-robin position.
- R10: Reset is synchronous and active low. After reset all busy bits are 0, both round-robin searches start at warp 0 and the cycle count is even.
- R11: A grant shows the warp's index on sN_warp and the warp's class code on sN_unit. The class code is bits [2w+1:2w] of sN_cls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s0_ready | input | NW | Scheduler 0: next instruction of warp w has all of its operands |
| s0_cls | input | 2*NW | Scheduler 0: 2-bit class code per warp |
| s0_prio | input | 2*NW | Scheduler 0: 2-bit priority per warp |
| s1_ready | input | NW | Scheduler 1: operand-ready flag per warp |
| s1_cls | input | 2*NW | Scheduler 1: class code per warp |
| s1_prio | input | 2*NW | Scheduler 1: priority per warp |
| s0_issue | output | 1 | Scheduler 0 grants this cycle |
| s0_warp | output | $clog2(NW) | Warp granted by scheduler 0 |
| s0_unit | output | 2 | Target group code of the scheduler 0 grant |
| s1_issue | output | 1 | Scheduler 1 grants this cycle |
| s1_warp | output | $clog2(NW) | Warp granted by scheduler 1 |
| s1_unit | output | 2 | Target group code of the scheduler 1 grant |
| grp_busy | output | 4 | Busy bits: [0] scheduler 0 arithmetic, [1] scheduler 1 arithmetic, [2] special function, [3] load/store |

## Verification
Directed patterns come first. One puts a lone ready warp beside an urgent warp that is not ready, which separates filtering on ready from filtering on priority. Mixed priorities and a pool of equal priority that wraps past the last warp tell the priority order apart from the round-robin order. Other patterns make the two schedulers collide on a shared group, once on an even cycle and once on an odd one, and pair a double-precision warp with an ordinary warp on the other side, which shows the alternation rule and the single-issue window. A long run of random ready, class and priority patterns is then compared cycle by cycle against a behavioural model. It catches interactions between busy groups, issue slots and pointers that the directed cases do not reach.

// File: rtl/ws_pkg.sv
// Shared definitions for the dual warp scheduler: class codes, group
// indices and a small helper. Assumes the 2-bit class code set below.
package ws_pkg;

    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_SFU = 2'd1,
        CLS_LSU = 2'd2,
        CLS_DP  = 2'd3
    } cls_e;

    localparam int GRP_ALU0 = 0;
    localparam int GRP_ALU1 = 1;
    localparam int GRP_SFU  = 2;
    localparam int GRP_LSU  = 3;
    localparam int NUM_GRP  = 4;
    localparam int NUM_TMR  = NUM_GRP + 2;  // four groups plus two issue slots

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ws_pick.sv
// Per-scheduler selector. Picks the most urgent eligible warp and
// breaks ties round-robin from ptr upward, wrapping at NW.
// Assumes elig already folds in readiness and resource availability.
module ws_pick #(
    parameter int NW = 8,
    parameter int PW = 2,
    parameter int WW = $clog2(NW)
) (
    input  logic [WW-1:0]    ptr,
    input  logic [NW-1:0]    elig,
    input  logic [PW*NW-1:0] prio,
    output logic             valid,
    output logic [WW-1:0]    warp
);
    localparam int NLVL = 1 << PW;

    logic [NLVL-1:0] lvl_hit;
    logic [PW-1:0]   best;

    function automatic int wrap_idx(int a);
        return (a >= NW) ? a - NW : a;
    endfunction

    // Mark each priority level held by at least one eligible warp.
    always_comb begin
        lvl_hit = '0;
        for (int w = 0; w < NW; w++) begin
            if (elig[w]) lvl_hit[prio[w*PW +: PW]] = 1'b1;
        end
    end

    // Highest populated priority level.
    always_comb begin
        best = '0;
        for (int p = 0; p < NLVL; p++) begin
            if (lvl_hit[p]) best = PW'(p);
        end
    end

    // First eligible warp at that level, searching upward from ptr.
    always_comb begin
        valid = 1'b0;
        warp  = '0;
        for (int i = 0; i < NW; i++) begin
            if (!valid && elig[wrap_idx(int'(ptr) + i)]
                && prio[wrap_idx(int'(ptr) + i)*PW +: PW] == best) begin
                valid = 1'b1;
                warp  = WW'(wrap_idx(int'(ptr) + i));
            end
        end
    end

endmodule

// File: rtl/ws_timer.sv
// Occupancy timer. A load holds busy for len cycles, the load cycle
// included, so busy shows for len-1 cycles afterwards.
// Assumes load only arrives while idle and len is at least 1.
module ws_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          busy
);
    logic [CW-1:0] cnt;

    // Count remaining occupied cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= len - CW'(1);
        else if (cnt != '0) cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/ws_resolve.sv
// Conflict resolution between the two candidates. Shared-group clashes
// and any double-precision candidate force a single grant, decided by
// cycle parity (0 = scheduler 0 wins).
module ws_resolve
    import ws_pkg::*;
(
    input  logic [1:0] cand_v,
    input  logic [1:0] cls0,
    input  logic [1:0] cls1,
    input  logic       phase,
    output logic [1:0] grant
);
    logic clash;

    // Detect whether both candidates may not issue together.
    always_comb begin
        clash = 1'b0;
        if (cand_v == 2'b11) begin
            if (cls0 == cls1 && (cls0 == CLS_SFU || cls0 == CLS_LSU)) clash = 1'b1;
            if (cls0 == CLS_DP || cls1 == CLS_DP)                     clash = 1'b1;
        end
    end

    // Drop the loser of a clash.
    always_comb begin
        grant[0] = cand_v[0] && !(clash && phase);
        grant[1] = cand_v[1] && !(clash && !phase);
    end

endmodule

// File: rtl/dual_warp_issue.sv
// Top of the dual warp scheduler. Two selectors feed a resolver, and
// timers track group occupancy and each scheduler's issue slot.
// Assumes operand readiness is supplied externally per warp.
module dual_warp_issue
    import ws_pkg::*;
#(
    parameter int NW        = 8,
    parameter int ALU_CYC   = 2,
    parameter int SFU_CYC   = 8,
    parameter int LSU_CYC   = 2,
    parameter int DP_CYC    = 2,
    parameter int ISSUE_CYC = 2,
    localparam int WW       = $clog2(NW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NW-1:0]   s0_ready,
    input  logic [2*NW-1:0] s0_cls,
    input  logic [2*NW-1:0] s0_prio,
    input  logic [NW-1:0]   s1_ready,
    input  logic [2*NW-1:0] s1_cls,
    input  logic [2*NW-1:0] s1_prio,
    output logic            s0_issue,
    output logic [WW-1:0]   s0_warp,
    output logic [1:0]      s0_unit,
    output logic            s1_issue,
    output logic [WW-1:0]   s1_warp,
    output logic [1:0]      s1_unit,
    output logic [3:0]      grp_busy
);
    localparam int MAXC = imax(imax(imax(ALU_CYC, SFU_CYC), imax(LSU_CYC, DP_CYC)), ISSUE_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    logic [NW-1:0]   rdy   [2];
    logic [2*NW-1:0] clsv  [2];
    logic [2*NW-1:0] priov [2];
    logic [NW-1:0]   elig  [2];
    logic [3:0]      cls_ok[2];
    logic [WW-1:0]   ptr   [2];
    logic [WW-1:0]   cand_w[2];
    logic [1:0]      ccls  [2];
    logic [1:0]      cand_v;
    logic [1:0]      grant;
    logic            phase;
    logic            dp_any;
    logic [NUM_TMR-1:0] t_busy;
    logic [NUM_TMR-1:0] t_load;
    logic [CW-1:0]      t_len [NUM_TMR];

    assign rdy[0]   = s0_ready;
    assign rdy[1]   = s1_ready;
    assign clsv[0]  = s0_cls;
    assign clsv[1]  = s1_cls;
    assign priov[0] = s0_prio;
    assign priov[1] = s1_prio;

    // Cycle parity used for conflict arbitration.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    // Which classes each scheduler could issue to right now.
    always_comb begin
        for (int s = 0; s < 2; s++) begin
            cls_ok[s][CLS_ALU] = !t_busy[s];
            cls_ok[s][CLS_SFU] = !t_busy[GRP_SFU];
            cls_ok[s][CLS_LSU] = !t_busy[GRP_LSU];
            cls_ok[s][CLS_DP]  = !t_busy[GRP_ALU0] && !t_busy[GRP_ALU1];
        end
    end

    for (genvar s = 0; s < 2; s++) begin : g_sched
        for (genvar w = 0; w < NW; w++) begin : g_elig
            assign elig[s][w] = rdy[s][w] && !t_busy[NUM_GRP + s]
                                && cls_ok[s][clsv[s][2*w +: 2]];
        end

        ws_pick #(.NW(NW), .PW(2), .WW(WW)) u_pick (
            .ptr   (ptr[s]),
            .elig  (elig[s]),
            .prio  (priov[s]),
            .valid (cand_v[s]),
            .warp  (cand_w[s])
        );

        assign ccls[s] = clsv[s][{cand_w[s], 1'b0} +: 2];

        // Round-robin pointer moves past the granted warp.
        always_ff @(posedge clk) begin
            if (!rst_n)        ptr[s] <= '0;
            else if (grant[s]) ptr[s] <= (int'(cand_w[s]) == NW - 1) ? '0 : cand_w[s] + WW'(1);
        end
    end

    ws_resolve u_resolve (
        .cand_v (cand_v),
        .cls0   (ccls[0]),
        .cls1   (ccls[1]),
        .phase  (phase),
        .grant  (grant)
    );

    assign dp_any = (grant[0] && ccls[0] == CLS_DP) || (grant[1] && ccls[1] == CLS_DP);

    // Timer loads and lengths for groups and issue slots.
    always_comb begin
        for (int s = 0; s < 2; s++) begin
            t_load[s]           = dp_any || (grant[s] && ccls[s] == CLS_ALU);
            t_len[s]            = dp_any ? CW'(DP_CYC) : CW'(ALU_CYC);
            t_load[NUM_GRP + s] = dp_any || grant[s];
            t_len[NUM_GRP + s]  = dp_any ? CW'(DP_CYC) : CW'(ISSUE_CYC);
        end
        t_load[GRP_SFU] = (grant[0] && ccls[0] == CLS_SFU) || (grant[1] && ccls[1] == CLS_SFU);
        t_len[GRP_SFU]  = CW'(SFU_CYC);
        t_load[GRP_LSU] = (grant[0] && ccls[0] == CLS_LSU) || (grant[1] && ccls[1] == CLS_LSU);
        t_len[GRP_LSU]  = CW'(LSU_CYC);
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        ws_timer #(.CW(CW)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (t_load[t]),
            .len   (t_len[t]),
            .busy  (t_busy[t])
        );
    end

    assign s0_issue = grant[0];
    assign s0_warp  = cand_w[0];
    assign s0_unit  = ccls[0];
    assign s1_issue = grant[1];
    assign s1_warp  = cand_w[1];
    assign s1_unit  = ccls[1];
    assign grp_busy = t_busy[NUM_GRP-1:0];

endmodule

// File: rtl/ws_checker.sv
// Port-level properties of the dual warp scheduler, bound to the top.
module ws_checker #(
    parameter int NW = 8,
    parameter int WW = $clog2(NW)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NW-1:0] s0_ready,
    input logic [NW-1:0] s1_ready,
    input logic          s0_issue,
    input logic [WW-1:0] s0_warp,
    input logic [1:0]    s0_unit,
    input logic          s1_issue,
    input logic [WW-1:0] s1_warp,
    input logic [1:0]    s1_unit,
    input logic [3:0]    grp_busy
);
    p_ready_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s0_issue |-> s0_ready[s0_warp]);
    p_ready_only_s1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s1_issue |-> s1_ready[s1_warp]);
    p_alu_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_issue && s0_unit == 2'd0) |=> grp_busy[0]);
    p_alu_hold_s1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_issue && s1_unit == 2'd0) |=> grp_busy[1]);
    p_sfu_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grp_busy[2] |-> !((s0_issue && s0_unit == 2'd1) || (s1_issue && s1_unit == 2'd1)));
    p_sfu_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_issue && s0_unit == 2'd1) |-> !(s1_issue && s1_unit == 2'd1));
    p_lsu_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grp_busy[3] |-> !((s0_issue && s0_unit == 2'd2) || (s1_issue && s1_unit == 2'd2)));
    p_dp_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((s0_issue && s0_unit == 2'd3) || (s1_issue && s1_unit == 2'd3)) |-> !(s0_issue && s1_issue));
    p_dp_claim_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((s0_issue && s0_unit == 2'd3) || (s1_issue && s1_unit == 2'd3)) |=> (grp_busy[1:0] == 2'b11 && !s0_issue && !s1_issue));
    p_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s0_issue |=> !s0_issue);
    p_rate_s1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s1_issue |=> !s1_issue);
endmodule

bind dual_warp_issue ws_checker #(.NW(NW), .WW(WW)) u_ws_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .s0_ready (s0_ready),
    .s1_ready (s1_ready),
    .s0_issue (s0_issue),
    .s0_warp  (s0_warp),
    .s0_unit  (s0_unit),
    .s1_issue (s1_issue),
    .s1_warp  (s1_warp),
    .s1_unit  (s1_unit),
    .grp_busy (grp_busy)
);

// File: tb/dual_warp_issue_test.sv
module dual_warp_issue_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NW = 8;
    localparam int WW = 3;
    localparam int ALU_CYC = 2, SFU_CYC = 8, LSU_CYC = 2, DP_CYC = 2, ISSUE_CYC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NW-1:0]   b_rdy  [2];
    logic [2*NW-1:0] b_cls  [2];
    logic [2*NW-1:0] b_prio [2];
    logic            s0_issue, s1_issue;
    logic [WW-1:0]   s0_warp, s1_warp;
    logic [1:0]      s0_unit, s1_unit;
    logic [3:0]      grp_busy;

    dual_warp_issue #(.NW(NW)) uut (
        .clk(clk), .rst_n(rst_n),
        .s0_ready(b_rdy[0]), .s0_cls(b_cls[0]), .s0_prio(b_prio[0]),
        .s1_ready(b_rdy[1]), .s1_cls(b_cls[1]), .s1_prio(b_prio[1]),
        .s0_issue(s0_issue), .s0_warp(s0_warp), .s0_unit(s0_unit),
        .s1_issue(s1_issue), .s1_warp(s1_warp), .s1_unit(s1_unit),
        .grp_busy(grp_busy)
    );

    int n_chk = 0, n_fail = 0;
    int m_alu [2] = '{0, 0};
    int m_port[2] = '{0, 0};
    int m_ptr [2] = '{0, 0};
    int m_sfu = 0, m_lsu = 0, m_phase = 0;
    int e_iss [2], e_warp[2], e_unit[2];

    function automatic int a_iss(int s);  return s ? int'(s1_issue) : int'(s0_issue); endfunction
    function automatic int a_warp(int s); return s ? int'(s1_warp)  : int'(s0_warp);  endfunction
    function automatic int a_unit(int s); return s ? int'(s1_unit)  : int'(s0_unit);  endfunction

    task automatic chk_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        for (int s = 0; s < 2; s++) begin
            b_rdy[s] = '0; b_cls[s] = '0; b_prio[s] = '0;
        end
    endtask

    task automatic put(int s, int w, int c, int p);
        b_rdy[s][w] = 1'b1;
        b_cls[s][2*w +: 2]  = 2'(c);
        b_prio[s][2*w +: 2] = 2'(p);
    endtask

    function automatic bit m_free(int s, int c);
        case (c)
            0: return m_alu[s] == 0;
            1: return m_sfu == 0;
            2: return m_lsu == 0;
            default: return m_alu[0] == 0 && m_alu[1] == 0;
        endcase
    endfunction

    // Behavioural expectation for the current cycle.
    task automatic model_eval();
        int cand[2];
        int cc[2];
        for (int s = 0; s < 2; s++) begin
            cand[s] = -1;
            cc[s] = 0;
            if (m_port[s] == 0) begin
                for (int p = 3; p >= 0; p--) begin
                    for (int i = 0; i < NW; i++) begin
                        int w = (m_ptr[s] + i) % NW;
                        int c = int'(b_cls[s][2*w +: 2]);
                        if (cand[s] < 0 && b_rdy[s][w] && int'(b_prio[s][2*w +: 2]) == p && m_free(s, c)) begin
                            cand[s] = w;
                            cc[s] = c;
                        end
                    end
                end
            end
            e_iss[s]  = (cand[s] >= 0) ? 1 : 0;
            e_warp[s] = cand[s];
            e_unit[s] = cc[s];
        end
        if (e_iss[0] == 1 && e_iss[1] == 1) begin
            if ((cc[0] == cc[1] && (cc[0] == 1 || cc[0] == 2)) || cc[0] == 3 || cc[1] == 3)
                e_iss[1 - m_phase] = 0;
        end
    endtask

    task automatic model_update();
        if (m_alu[0] > 0) m_alu[0]--;
        if (m_alu[1] > 0) m_alu[1]--;
        if (m_port[0] > 0) m_port[0]--;
        if (m_port[1] > 0) m_port[1]--;
        if (m_sfu > 0) m_sfu--;
        if (m_lsu > 0) m_lsu--;
        for (int s = 0; s < 2; s++) begin
            if (e_iss[s] == 1) begin
                if (e_unit[s] == 3) begin
                    m_alu[0] = DP_CYC - 1; m_alu[1] = DP_CYC - 1;
                    m_port[0] = DP_CYC - 1; m_port[1] = DP_CYC - 1;
                end else begin
                    m_port[s] = ISSUE_CYC - 1;
                    if (e_unit[s] == 0) m_alu[s] = ALU_CYC - 1;
                    if (e_unit[s] == 1) m_sfu = SFU_CYC - 1;
                    if (e_unit[s] == 2) m_lsu = LSU_CYC - 1;
                end
                m_ptr[s] = (e_warp[s] + 1) % NW;
            end
        end
        m_phase = 1 - m_phase;
    endtask

    // Sample just before the rising edge and compare with the model.
    task automatic peek();
        int eb;
        #4;
        model_eval();
        for (int s = 0; s < 2; s++) begin
            chk_eq($sformatf("R1/R2/R3/R8/R9 issue s%0d", s), a_iss(s), e_iss[s]);
            if (e_iss[s] == 1) begin
                chk_eq($sformatf("R2/R3 warp s%0d", s), a_warp(s), e_warp[s]);
                chk_eq($sformatf("R11 unit s%0d", s), a_unit(s), e_unit[s]);
            end
        end
        eb = ((m_lsu != 0) ? 8 : 0) | ((m_sfu != 0) ? 4 : 0) |
             ((m_alu[1] != 0) ? 2 : 0) | ((m_alu[0] != 0) ? 1 : 0);
        chk_eq("R4/R5/R6/R7 busy", int'(grp_busy), eb);
    endtask

    task automatic adv();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic step();
        peek();
        adv();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        clr();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: idle after reset
        peek();
        chk_eq("R10 busy after reset", int'(grp_busy), 0);
        chk_eq("R10 no grant s0", int'(s0_issue), 0);
        adv();

        // R1: urgent warp 0 not ready; R10: s1 search starts at warp 0
        put(0, 3, 0, 0);
        b_prio[0][1:0] = 2'd3;
        put(1, 0, 0, 0);
        put(1, 5, 0, 0);
        peek();
        chk_eq("R1 grant s0", int'(s0_issue), 1);
        chk_eq("R1 warp s0", int'(s0_warp), 3);
        chk_eq("R11 unit s0", int'(s0_unit), 0);
        chk_eq("R10 first rr warp s1", int'(s1_warp), 0);
        adv();
        clr();
        peek();
        chk_eq("R4 arithmetic groups held", int'(grp_busy[1:0]), 3);
        adv();

        // R2: priority 3 beats priority 1; ptr0 is 4
        put(0, 1, 0, 1);
        put(0, 5, 0, 3);
        put(0, 6, 0, 3);
        peek();
        chk_eq("R2 most urgent warp", int'(s0_warp), 5);
        adv();
        clr();
        step();

        // R3: equal priority, round-robin with wrap
        put(0, 2, 0, 3);
        put(0, 5, 0, 3);
        put(0, 6, 0, 3);
        peek();
        chk_eq("R3 rr after 5", int'(s0_warp), 6);
        adv();
        step();
        peek();
        chk_eq("R3 rr wraps", int'(s0_warp), 2);
        adv();
        clr();
        step();

        // R5: special-function group held 8 cycles
        put(0, 0, 1, 0);
        peek();
        chk_eq("R5 sfu grant s0", int'(s0_issue), 1);
        chk_eq("R5 sfu unit", int'(s0_unit), 1);
        adv();
        clr();
        put(1, 0, 1, 0);
        for (int k = 1; k <= 7; k++) begin
            peek();
            chk_eq("R5 sfu busy", int'(grp_busy[2]), 1);
            chk_eq("R5 sfu blocked s1", int'(s1_issue), 0);
            adv();
        end
        peek();
        chk_eq("R5 sfu free again s1", int'(s1_issue), 1);
        adv();
        clr();
        step();
        step();

        // R9 and R6: load/store clash on even and odd cycles
        for (int it = 0; it < 2; it++) begin
            while (m_phase != it) step();
            put(0, 4, 2, 0);
            put(1, 4, 2, 0);
            peek();
            chk_eq("R9 parity winner", a_iss(it), 1);
            chk_eq("R9 parity loser", a_iss(1 - it), 0);
            adv();
            clr();
            put(1 - it, 4, 2, 0);
            peek();
            chk_eq("R6 lsu busy", int'(grp_busy[3]), 1);
            chk_eq("R6 lsu blocks loser", a_iss(1 - it), 0);
            adv();
            peek();
            chk_eq("R6 loser retries", a_iss(1 - it), 1);
            chk_eq("R9 loser keeps warp", a_warp(1 - it), 4);
            adv();
            clr();
            step();
            step();
        end

        // R7: double precision issues alone and blocks the other side
        while (m_phase != 0) step();
        put(0, 1, 3, 0);
        put(1, 2, 1, 0);
        peek();
        chk_eq("R7 dp grant", int'(s0_issue), 1);
        chk_eq("R7 dp unit", int'(s0_unit), 3);
        chk_eq("R7 dp alone", int'(s1_issue), 0);
        adv();
        clr();
        put(1, 2, 1, 0);
        peek();
        chk_eq("R7 both arithmetic held", int'(grp_busy[1:0]), 3);
        chk_eq("R7 other side blocked", int'(s1_issue), 0);
        adv();
        peek();
        chk_eq("R7 other side resumes", int'(s1_issue), 1);
        adv();
        clr();
        step();
        step();

        // R9/R7: double precision loses on an odd cycle
        while (m_phase != 1) step();
        put(0, 1, 3, 0);
        put(1, 2, 0, 0);
        peek();
        chk_eq("R9 odd winner s1", int'(s1_issue), 1);
        chk_eq("R9 dp loses", int'(s0_issue), 0);
        adv();
        clr();
        put(0, 1, 3, 0);
        peek();
        chk_eq("R7 dp waits for group", int'(s0_issue), 0);
        adv();
        peek();
        chk_eq("R7 dp then issues", int'(s0_issue), 1);
        adv();
        clr();
        step();
        step();

        // R8: one grant per two cycles, both schedulers together
        put(0, 3, 0, 0);
        put(1, 3, 0, 0);
        for (int k = 0; k < 6; k++) begin
            peek();
            chk_eq("R8 s0 cadence", int'(s0_issue), (k % 2 == 0) ? 1 : 0);
            chk_eq("R8 s1 cadence", int'(s1_issue), (k % 2 == 0) ? 1 : 0);
            adv();
        end
        clr();

        // Random patterns against the model
        for (int k = 0; k < 400; k++) begin
            for (int s = 0; s < 2; s++) begin
                b_rdy[s]  = NW'($urandom);
                b_cls[s]  = (2*NW)'($urandom);
                b_prio[s] = (2*NW)'($urandom);
            end
            step();
        end

        summary();
        $finish;
    end

endmodule